// File: doc/BRIEF.md
# Prioritized Interrupt Pending Controller

This block gathers a set of interrupt request lines and keeps a pending bit, an enable bit and a small priority value for each line. A request line sets its pending bit. Software sets or clears pending bits and enable bits through write-one registers that come in set and clear pairs. Software writes the priority values into a bank of 32-bit registers that hold four fields each.

Every cycle the block picks the enabled pending line with the most urgent priority. It registers the index of that line and a valid flag for the processor. When the processor acknowledges, the pending bit of the presented line is cleared. A separate non-maskable input keeps its own pending bit. That bit ignores the enable bits and takes precedence over every ordinary line.

Top module: `prio_irq_hub`

## Requirements
- R1: A high level on `irqReq[i]` at a clock edge sets pending bit i. The bit stays set after the request drops, and it is visible on `pendState[i]`.
- R2: A write to word address 2 sets every pending bit whose data bit is 1. A write to address 3 clears every pending bit whose data bit is 1. Data bits that are 0 leave the pending bits unchanged.
- R3: A write to address 0 sets the enable bits selected by the data 1s, and a write to address 1 clears them. An ordinary line can be presented only while it is both pending and enabled.
- R4: The priority of line 4b+k sits in data bits [8k+2:8k] of the register at word address 4+b. Data bits [8k+7:8k+3] are ignored.
- R5: A lower priority value wins. When two candidates have equal values, the lower line index wins.
- R6: `irqValid`, `irqNmi` and `irqIdx` are registered from the pending, enable and priority state. They change one cycle after that state changes.
- R7: `ackIn` while `irqValid` is 1 clears the pending bit of the line shown on `irqIdx`, or the non-maskable pending bit when `irqNmi` is 1. `ackIn` has no effect while `irqValid` is 0.
- R8: An acknowledge or a clear-pending write beats a request in the same cycle. A request that stays high sets the bit again at the next edge.
- R9: `nmiReq` sets a non-maskable pending bit that ignores the enable bits. While that bit is set, the outputs show `irqValid`=1, `irqNmi`=1 and `irqIdx`=0.
- R10: Reset clears all pending bits, enable bits, priority fields and outputs.
- R11: Writes to word addresses above 4+NUM_BANKS-1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqReq | input | NUM_LINES | Request lines, active high |
| nmiReq | input | 1 | Non-maskable request |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Register word address |
| wrData | input | 32 | Register write data |
| ackIn | input | 1 | Processor acknowledge of the presented interrupt |
| irqValid | output | 1 | An interrupt is being presented |
| irqNmi | output | 1 | The presented interrupt is the non-maskable one |
| irqIdx | output | IDX_W | Index of the presented line |
| pendState | output | NUM_LINES | Pending bits |
| enaState | output | NUM_LINES | Enable bits |

## Verification
Two things can happen to the same pending bit in one cycle: the processor acknowledges the line, and that line's request is still high. The bench holds a request high, waits until that line is presented, and then pulses the acknowledge with the request still asserted. The pending bit must read 0 after that edge and 1 again after the following edge. A table of register writes, requests and acknowledges then checks the tie-break on index, the masking of upper bits in the priority fields, and the way the non-maskable bit takes precedence.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

  // Register layout constants
  localparam int FIELDS_PER_REG = 4;
  localparam int FIELD_STRIDE   = 8;
  localparam int FIRST_PRIO_REG = 4;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic setEn;
    logic clrEn;
    logic setPnd;
    logic clrPnd;
    logic prioWr;
    logic ackLine;
    logic ackNmi;
  } strobe_t;

endpackage

// File: rtl/prio_irq_arb.sv
module prio_irq_arb #(
  parameter int NUM_LINES = 8,
  parameter int PRIO_W    = 3,
  parameter int IDX_W     = 3
) (
  input  logic [NUM_LINES-1:0]        cand,
  input  logic [NUM_LINES*PRIO_W-1:0] prioFlat,
  output logic                        anyHit,
  output logic [IDX_W-1:0]            bestIdx
);

  logic [PRIO_W-1:0] bestPrio;

  // Scan upward and replace only on a strictly lower value, so the lower index keeps a tie
  always_comb begin
    anyHit   = 1'b0;
    bestIdx  = '0;
    bestPrio = '1;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (cand[i] && (!anyHit || (prioFlat[i*PRIO_W +: PRIO_W] < bestPrio))) begin
        anyHit   = 1'b1;
        bestIdx  = IDX_W'(i);
        bestPrio = prioFlat[i*PRIO_W +: PRIO_W];
      end
    end
  end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 3,
  parameter int BANK_W    = 1
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              ackIn,
  input  logic              irqValid,
  input  logic              irqNmi,
  output strobe_t           st,
  output logic [BANK_W-1:0] bankSel
);

  localparam int LAST_REG = FIRST_PRIO_REG + NUM_BANKS - 1;

  always_comb begin
    st      = '0;
    bankSel = '0;
    if (wrEn) begin
      if (int'(wrAddr) == 0)      st.setEn  = 1'b1;
      else if (int'(wrAddr) == 1) st.clrEn  = 1'b1;
      else if (int'(wrAddr) == 2) st.setPnd = 1'b1;
      else if (int'(wrAddr) == 3) st.clrPnd = 1'b1;
      else if (int'(wrAddr) <= LAST_REG) begin
        st.prioWr = 1'b1;
        bankSel   = BANK_W'(int'(wrAddr) - FIRST_PRIO_REG);
      end
    end
    // An acknowledge counts only while something is presented
    st.ackLine = ackIn && irqValid && !irqNmi;
    st.ackNmi  = ackIn && irqValid && irqNmi;
  end

endmodule

// File: rtl/prio_irq_dp.sv
module prio_irq_dp
  import prio_irq_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int PRIO_W    = 3,
  parameter int BANK_W    = 1,
  parameter int IDX_W     = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqReq,
  input  logic                 nmiReq,
  input  strobe_t              st,
  input  logic [BANK_W-1:0]    bankSel,
  input  logic [31:0]          wrData,
  output logic                 irqValid,
  output logic                 irqNmi,
  output logic [IDX_W-1:0]     irqIdx,
  output logic [NUM_LINES-1:0] pendQ,
  output logic [NUM_LINES-1:0] enQ
);

  logic [NUM_LINES-1:0][PRIO_W-1:0] prioQ;
  logic [NUM_LINES*PRIO_W-1:0]      prioFlat;
  logic                             nmiPend;
  logic [NUM_LINES-1:0]             swSet, swClr, ackMask, enSet, enClr;
  logic                             anyHit;
  logic [IDX_W-1:0]                 bestIdx;

  assign swSet   = st.setPnd  ? wrData[NUM_LINES-1:0] : '0;
  assign swClr   = st.clrPnd  ? wrData[NUM_LINES-1:0] : '0;
  assign enSet   = st.setEn   ? wrData[NUM_LINES-1:0] : '0;
  assign enClr   = st.clrEn   ? wrData[NUM_LINES-1:0] : '0;
  assign ackMask = st.ackLine ? (NUM_LINES'(1) << irqIdx) : '0;
  assign prioFlat = prioQ;

  // Pending and enable state; clears beat sets in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ   <= '0;
      enQ     <= '0;
      nmiPend <= 1'b0;
    end else begin
      pendQ   <= (pendQ | irqReq | swSet) & ~(swClr | ackMask);
      enQ     <= (enQ | enSet) & ~enClr;
      nmiPend <= (nmiPend | nmiReq) & ~st.ackNmi;
    end
  end

  // Priority bank: line i sits in register i/4, byte i%4
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prioQ <= '0;
    end else if (st.prioWr) begin
      for (int i = 0; i < NUM_LINES; i++) begin
        if (bankSel == BANK_W'(i / FIELDS_PER_REG))
          prioQ[i] <= wrData[(i % FIELDS_PER_REG)*FIELD_STRIDE +: PRIO_W];
      end
    end
  end

  prio_irq_arb #(
    .NUM_LINES(NUM_LINES),
    .PRIO_W   (PRIO_W),
    .IDX_W    (IDX_W)
  ) u_arb (
    .cand    (pendQ & enQ),
    .prioFlat(prioFlat),
    .anyHit  (anyHit),
    .bestIdx (bestIdx)
  );

  // Registered presentation to the processor
  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqValid <= 1'b0;
      irqNmi   <= 1'b0;
      irqIdx   <= '0;
    end else begin
      irqValid <= nmiPend || anyHit;
      irqNmi   <= nmiPend;
      irqIdx   <= nmiPend ? '0 : bestIdx;
    end
  end

  // R1: a pending bit rises only from a request or a software set
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_pendChk
    a_r1_pend_source: assert property (@(posedge clk) disable iff (!rstN)
      $rose(pendQ[g]) |-> $past(irqReq[g] || (st.setPnd && wrData[g])));
  end

  // R7: an accepted acknowledge without a competing request leaves the line clear
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    (st.ackLine && !irqReq[irqIdx]) |=> !pendQ[$past(irqIdx)]);

  // R9: non-maskable pending always takes the output
  a_r9_nmi_wins: assert property (@(posedge clk) disable iff (!rstN)
    nmiPend |=> (irqValid && irqNmi && (irqIdx == '0)));

  // R3: nothing presented when no enabled line is pending
  a_r3_masked_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!nmiPend && ((pendQ & enQ) == '0)) |=> !irqValid);

endmodule

// File: rtl/prio_irq_hub.sv
module prio_irq_hub
  import prio_irq_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int PRIO_W    = 3,
  localparam int NUM_BANKS = (NUM_LINES + FIELDS_PER_REG - 1) / FIELDS_PER_REG,
  localparam int ADDR_W    = $clog2(FIRST_PRIO_REG + NUM_BANKS),
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqReq,
  input  logic                 nmiReq,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [31:0]          wrData,
  input  logic                 ackIn,
  output logic                 irqValid,
  output logic                 irqNmi,
  output logic [IDX_W-1:0]     irqIdx,
  output logic [NUM_LINES-1:0] pendState,
  output logic [NUM_LINES-1:0] enaState
);

  strobe_t           st;
  logic [BANK_W-1:0] bankSel;

  prio_irq_ctrl #(
    .NUM_BANKS(NUM_BANKS),
    .ADDR_W   (ADDR_W),
    .BANK_W   (BANK_W)
  ) u_ctrl (
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .ackIn   (ackIn),
    .irqValid(irqValid),
    .irqNmi  (irqNmi),
    .st      (st),
    .bankSel (bankSel)
  );

  prio_irq_dp #(
    .NUM_LINES(NUM_LINES),
    .PRIO_W   (PRIO_W),
    .BANK_W   (BANK_W),
    .IDX_W    (IDX_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .irqReq  (irqReq),
    .nmiReq  (nmiReq),
    .st      (st),
    .bankSel (bankSel),
    .wrData  (wrData),
    .irqValid(irqValid),
    .irqNmi  (irqNmi),
    .irqIdx  (irqIdx),
    .pendQ   (pendState),
    .enQ     (enaState)
  );

endmodule

// File: tb/sim_prio_irq_hub.sv
module sim_prio_irq_hub;

  localparam int CLK_PERIOD = 10;
  localparam int NL = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NL-1:0] irqReq = '0;
  logic          nmiReq = 1'b0;
  logic          wrEn = 1'b0;
  logic [2:0]    wrAddr = '0;
  logic [31:0]   wrData = '0;
  logic          ackIn = 1'b0;
  logic          irqValid, irqNmi;
  logic [2:0]    irqIdx;
  logic [NL-1:0] pendState, enaState;

  int nRun = 0;
  int nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_hub #(.NUM_LINES(NL), .PRIO_W(3)) u0 (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .nmiReq(nmiReq),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .ackIn(ackIn),
    .irqValid(irqValid), .irqNmi(irqNmi), .irqIdx(irqIdx),
    .pendState(pendState), .enaState(enaState)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic        nmi;
    logic        we;
    logic [2:0]  wa;
    logic [31:0] wd;
    logic        ack;
    logic [12:0] exp;   // {valid, nmi, idx[2:0], pend[7:0]}
  } vec_t;

  // Each row: drive one cycle, idle one cycle, then compare
  localparam vec_t TABLE [14] = '{
    '{8'h00, 1'b0, 1'b1, 3'd0, 32'h0000_00FF, 1'b0, {1'b0,1'b0,3'd0,8'h00}}, // R3 enable all
    '{8'h20, 1'b0, 1'b0, 3'd0, 32'h0,         1'b0, {1'b1,1'b0,3'd5,8'h20}}, // R1 line 5
    '{8'h08, 1'b0, 1'b0, 3'd0, 32'h0,         1'b0, {1'b1,1'b0,3'd3,8'h28}}, // R5 tie -> 3
    '{8'h00, 1'b0, 1'b1, 3'd4, 32'h0500_0000, 1'b0, {1'b1,1'b0,3'd5,8'h28}}, // R4 line3=5
    '{8'h00, 1'b0, 1'b1, 3'd5, 32'h0000_0E07, 1'b0, {1'b1,1'b0,3'd3,8'h28}}, // R4 line5=6, bit3 ignored
    '{8'h00, 1'b0, 1'b1, 3'd1, 32'h0000_0008, 1'b0, {1'b1,1'b0,3'd5,8'h28}}, // R3 disable 3
    '{8'h00, 1'b0, 1'b0, 3'd0, 32'h0,         1'b1, {1'b0,1'b0,3'd0,8'h08}}, // R7 ack line5
    '{8'h00, 1'b0, 1'b1, 3'd0, 32'h0000_0008, 1'b0, {1'b1,1'b0,3'd3,8'h08}}, // R3 re-enable
    '{8'h00, 1'b0, 1'b1, 3'd2, 32'h0000_0001, 1'b0, {1'b1,1'b0,3'd0,8'h09}}, // R2 sw set
    '{8'h00, 1'b0, 1'b1, 3'd3, 32'h0000_0009, 1'b0, {1'b0,1'b0,3'd0,8'h00}}, // R2 sw clear
    '{8'h80, 1'b1, 1'b0, 3'd0, 32'h0,         1'b0, {1'b1,1'b1,3'd0,8'h80}}, // R9 nmi wins
    '{8'h00, 1'b0, 1'b0, 3'd0, 32'h0,         1'b1, {1'b1,1'b0,3'd7,8'h80}}, // R9 ack nmi
    '{8'h00, 1'b0, 1'b0, 3'd0, 32'h0,         1'b1, {1'b0,1'b0,3'd0,8'h00}}, // R7 ack line7
    '{8'h00, 1'b0, 1'b1, 3'd7, 32'hFFFF_FFFF, 1'b0, {1'b0,1'b0,3'd0,8'h00}}  // R11 unmapped
  };

  task automatic chk(input string tag, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [12:0] snap();
    return {irqValid, irqNmi, irqIdx, pendState};
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    chk("R10 reset", snap() == 13'h0 && enaState == '0, {19'h0, snap()}, 32'h0);
    rstN = 1'b1;

    for (int v = 0; v < 14; v++) begin
      @(negedge clk);
      irqReq = TABLE[v].req; nmiReq = TABLE[v].nmi; wrEn = TABLE[v].we;
      wrAddr = TABLE[v].wa;  wrData = TABLE[v].wd;  ackIn = TABLE[v].ack;
      @(posedge clk);
      @(negedge clk);
      irqReq = '0; nmiReq = 1'b0; wrEn = 1'b0; ackIn = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk($sformatf("R5 table row %0d", v), snap() == TABLE[v].exp,
          {19'h0, snap()}, {19'h0, TABLE[v].exp});
    end
    // R11: unmapped write left enables intact
    chk("R11 enables", enaState == 8'hFF, {24'h0, enaState}, 32'hFF);

    // R6: pending updates at the first edge, output at the second
    irqReq = 8'h04;
    @(posedge clk);
    @(negedge clk);
    chk("R6 pend early", pendState == 8'h04 && !irqValid, {23'h0, irqValid, pendState}, 32'h04);
    @(posedge clk);
    @(negedge clk);
    chk("R6 output late", irqValid && irqIdx == 3'd2, {28'h0, irqValid, irqIdx}, 32'hA);

    // R8: ack with the request still high clears, then the request sets again
    ackIn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ackIn = 1'b0;
    chk("R8 cleared by ack", pendState[2] == 1'b0, {31'h0, pendState[2]}, 32'h0);
    @(posedge clk);
    @(negedge clk);
    chk("R8 set again", pendState[2] == 1'b1, {31'h0, pendState[2]}, 32'h1);
    irqReq = '0;

    // R7: ack with nothing valid has no effect on later state
    wrEn = 1'b1; wrAddr = 3'd3; wrData = 32'h04;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
    @(posedge clk);
    @(negedge clk);
    ackIn = 1'b1; irqReq = 8'h02;
    @(posedge clk);
    @(negedge clk);
    ackIn = 1'b0; irqReq = '0;
    chk("R7 ack ignored when idle", pendState == 8'h02, {24'h0, pendState}, 32'h02);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nRun++;
    nFail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule